// File: doc/BRIEF.md
# Upper-memory shadow attribute decoder

This block decides where each memory access in the upper part of the first megabyte, and in a band of regions just under the 16 MB line, is routed. It returns one of four codes: on-board DRAM (internal), the expansion bus only (external), any external responder, or "not decoded here". The code is chosen by the access address, by the direction of the access, and by a small set of configuration bytes held in the block. Read and write routing are decided separately, so a ROM image can be read from shadow DRAM while writes still go out to the bus, or the reverse.

The window 0xA0000–0xFFFFF is divided into 24 pages of 16 KB. The display pages (0xA0000–0xBFFFF) always go out on the bus. The option-ROM pages (0xC0000–0xDFFFF) and the system-ROM pages (0xE0000–0xFFFFF) can each be shadowed under a per-segment enable bit and a per-direction master gate. Where shadowing is off, a per-area select bit picks the fallback. The area 0xF80000–0xFEFFFF is built from one 64 KB region and six pairs of 32 KB halves, and each can be internal or external-any. An expanded-memory hit from a neighbouring translator overrides everything and forces internal routing. The configuration bytes are loaded through a simple indexed write port and reset to fixed defaults. The route output follows the address combinationally.

Top module: `shadow_attr_dec`

## Requirements
- R1: After reset every configuration byte is zero except byte 0, which holds 0x02. Accesses to 0xC0000–0xEFFFF therefore route external, 0xF0000–0xFFFFF route external-any, and 0xF80000–0xFEFFFF route internal. Route codes are 0 internal, 1 external, 2 external-any, 3 not decoded.
- R2: Addresses 0xA0000–0xBFFFF always route external (code 1), whatever the configuration.
- R3: In 0xC0000–0xDFFFF, byte 13 bit n enables the 32 KB block at 0xC0000 + n×0x8000. A read is internal only when that bit and byte 2 bit 2 are both set. A write is internal only when that bit and byte 2 bit 3 are both set.
- R4: When a 0xC0000–0xDFFFF access is not internal, it routes external-any if the select bit is set and external otherwise. The select bit is byte 7 bit 6 for 0xC0000–0xCFFFF and byte 7 bit 7 for 0xD0000–0xDFFFF.
- R5: Byte 12 bit 4 enables 0xE0000–0xEFFFF and byte 12 bit 5 enables 0xF0000–0xFFFFF. A read there is internal only with byte 2 bit 0 also set, and a write only with byte 2 bit 1 also set.
- R6: When not internal, 0xE0000–0xEFFFF routes external-any if byte 12 bit 4 is set and external otherwise. 0xF0000–0xFFFFF always falls back to external-any.
- R7: The read route and the write route of a page are independent. With only the read gate set, an enabled page is internal for reads and external for writes, and the reverse holds with only the write gate set.
- R8: The 64 KB region 0xFE0000–0xFEFFFF routes external-any when byte 0 bit 6 is set and internal otherwise.
- R9: For k = 1..6, the region at 0xFE0000 − k×0x10000 is governed by byte k. Bit 6 set makes its lower 32 KB external-any and bit 7 set makes its upper 32 KB external-any. A clear bit leaves that half internal.
- R10: While the expanded-memory hit input is high the route is internal (code 0) for any address and direction.
- R11: Addresses outside 0xA0000–0xFFFFF and 0xF80000–0xFEFFFF, with no expanded-memory hit, return code 3.
- R12: A configuration write (index on cfg_idx_i, byte on cfg_data_i, strobe cfg_we_i) is captured at a rising clock edge and governs every access from that edge on. Without a write, the route depends only on the present address, direction and hit input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration bytes |
| rst_ni | input | 1 | Asynchronous active-low reset to the default bytes |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 4 | Configuration byte index |
| cfg_data_i | input | 8 | Configuration byte value |
| addr_i | input | ADDR_W (24) | Access byte address |
| wr_i | input | 1 | Access direction, 1 for write |
| ems_hit_i | input | 1 | Expanded-memory translator claims the access |
| route_o | output | 2 | Route code: 0 internal, 1 external, 2 external-any, 3 not decoded |

## Verification
The route is combinational from the address, direction and hit inputs, so it is due in the same cycle the inputs change. The bench drives those inputs on the falling edge and samples two nanoseconds later, well before the next rising edge. A configuration byte only counts from the rising edge that captures the write. The bench therefore holds the strobe across one rising edge and drops it on the following falling edge, and only probes after that. It also updates its own copy of the bytes at that point. The checker relies on the same timing and expects the route to stay unchanged from one edge to the next unless a write was taken in between or an input moved.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;

   typedef enum logic [1:0] {
      ROUTE_INT  = 2'b00,
      ROUTE_EXT  = 2'b01,
      ROUTE_ANY  = 2'b10,
      ROUTE_NONE = 2'b11
   } route_e;

   localparam int unsigned PAGE_SHIFT     = 14;
   localparam int unsigned WIN_FIRST_PAGE = 40;   // 0xA0000 >> 14
   localparam int unsigned SHADOW_OFFSET  = 8;    // first shadowable page in the window
   localparam int unsigned SHADOW_PAGES   = 16;
   localparam int unsigned CFG_IDX_W      = 4;
   localparam int unsigned CFG_NREGS      = 1 << CFG_IDX_W;

   // configuration byte indices the decode depends on
   localparam int unsigned IDX_TOPSEG  = 0;
   localparam int unsigned IDX_GATES   = 2;
   localparam int unsigned IDX_FALLBK  = 7;
   localparam int unsigned IDX_EFSEG   = 12;
   localparam int unsigned IDX_CDSEG   = 13;

   localparam logic [7:0] TOP_SEG_TAG = 8'hFE;

endpackage

// File: rtl/shadow_attr_cfg.sv
module shadow_attr_cfg #(
   parameter int unsigned         NREGS     = 16,
   parameter int unsigned         IDX_W     = 4,
   parameter logic [NREGS-1:0]    WMASK     = '1,
   parameter logic [NREGS*8-1:0]  RST_IMAGE = '0
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    we_i,
   input  logic [IDX_W-1:0]        idx_i,
   input  logic [7:0]              data_i,
   output logic [NREGS-1:0][7:0]   regs_o
);

   if (NREGS > (1 << IDX_W)) begin : g_bad_idx
      $error("shadow_attr_cfg: NREGS exceeds index range");
   end

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      if (WMASK[g]) begin : g_store
         logic [7:0] q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               q <= RST_IMAGE[g*8 +: 8];
            end else if (we_i && (idx_i == IDX_W'(g))) begin
               q <= data_i;
            end
         end
         assign regs_o[g] = q;
      end else begin : g_const
         assign regs_o[g] = RST_IMAGE[g*8 +: 8];
      end
   end

endmodule

// File: rtl/shadow_attr_page.sv
module shadow_attr_page
   import shadow_attr_pkg::*;
(
   input  logic   en_i,
   input  logic   rd_gate_i,
   input  logic   wr_gate_i,
   input  logic   fb_any_i,
   output route_e rd_o,
   output route_e wr_o
);

   route_e fallback;

   assign fallback = fb_any_i ? ROUTE_ANY : ROUTE_EXT;
   assign rd_o     = (en_i && rd_gate_i) ? ROUTE_INT : fallback;
   assign wr_o     = (en_i && wr_gate_i) ? ROUTE_INT : fallback;

endmodule

// File: rtl/shadow_attr_hiregion.sv
module shadow_attr_hiregion
   import shadow_attr_pkg::*;
#(
   parameter logic [7:0] TAG   = 8'hFE,
   parameter bit         SPLIT = 1'b0
) (
   input  logic [7:0] seg_i,
   input  logic       half_i,
   input  logic [7:0] ctl_i,
   output logic       hit_o,
   output route_e     route_o
);

   logic sel_any;

   if (SPLIT) begin : g_split
      assign sel_any = half_i ? ctl_i[7] : ctl_i[6];
   end else begin : g_whole
      assign sel_any = ctl_i[6];
   end

   assign hit_o   = (seg_i == TAG);
   assign route_o = sel_any ? ROUTE_ANY : ROUTE_INT;

endmodule

// File: rtl/shadow_attr_dec.sv
module shadow_attr_dec
   import shadow_attr_pkg::*;
#(
   parameter int unsigned            ADDR_W    = 24,
   parameter int unsigned            NUM_SPLIT = 6,
   parameter logic [CFG_NREGS*8-1:0] RST_IMAGE = {{(CFG_NREGS-1){8'h00}}, 8'h02}
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  cfg_we_i,
   input  logic [CFG_IDX_W-1:0]  cfg_idx_i,
   input  logic [7:0]            cfg_data_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic                  wr_i,
   input  logic                  ems_hit_i,
   output logic [1:0]            route_o
);

   localparam int unsigned NHI = NUM_SPLIT + 1;
   localparam logic [CFG_NREGS-1:0] WMASK =
      CFG_NREGS'((1 << (NUM_SPLIT + 1)) - 1) |
      (CFG_NREGS'(1) << IDX_GATES) | (CFG_NREGS'(1) << IDX_FALLBK) |
      (CFG_NREGS'(1) << IDX_EFSEG) | (CFG_NREGS'(1) << IDX_CDSEG);

   if (ADDR_W < 24) begin : g_bad_aw
      $error("shadow_attr_dec: ADDR_W must be at least 24");
   end
   if ((NUM_SPLIT < 1) || (NUM_SPLIT > 6)) begin : g_bad_split
      $error("shadow_attr_dec: NUM_SPLIT must be 1..6");
   end

   logic [CFG_NREGS-1:0][7:0] cfg;

   shadow_attr_cfg #(
      .NREGS     (CFG_NREGS),
      .IDX_W     (CFG_IDX_W),
      .WMASK     (WMASK),
      .RST_IMAGE (RST_IMAGE)
   ) u_cfg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_we_i),
      .idx_i  (cfg_idx_i),
      .data_i (cfg_data_i),
      .regs_o (cfg)
   );

   // ---------------- address fields ----------------
   logic       above_16m_zero;
   logic       below_1m;
   logic [5:0] page;
   logic       win_hit;
   logic [4:0] win_idx;
   logic [4:0] sh_off;
   logic [7:0] seg;

   if (ADDR_W > 24) begin : g_wide
      assign above_16m_zero = (addr_i[ADDR_W-1:24] == '0);
   end else begin : g_narrow
      assign above_16m_zero = 1'b1;
   end

   assign below_1m = above_16m_zero && (addr_i[23:20] == 4'h0);
   assign page     = addr_i[19:PAGE_SHIFT];
   assign win_hit  = below_1m && (page >= 6'(WIN_FIRST_PAGE));
   assign win_idx  = 5'(page - 6'(WIN_FIRST_PAGE));
   assign sh_off   = win_idx - 5'(SHADOW_OFFSET);
   assign seg      = addr_i[23:16];

   // ---------------- shadowable pages ----------------
   route_e pg_rd [SHADOW_PAGES];
   route_e pg_wr [SHADOW_PAGES];

   for (genvar g = 0; g < SHADOW_PAGES; g++) begin : g_page
      localparam int unsigned P = g + SHADOW_OFFSET;
      logic en, rg, wg, fb;
      if (P < 16) begin : g_cd
         assign en = cfg[IDX_CDSEG][(P - 8) >> 1];
         assign rg = cfg[IDX_GATES][2];
         assign wg = cfg[IDX_GATES][3];
         if (P < 12) begin : g_c
            assign fb = cfg[IDX_FALLBK][6];
         end else begin : g_d
            assign fb = cfg[IDX_FALLBK][7];
         end
      end else begin : g_ef
         assign en = cfg[IDX_EFSEG][((P - 8) >> 2) + 2];
         assign rg = cfg[IDX_GATES][0];
         assign wg = cfg[IDX_GATES][1];
         if (P < 20) begin : g_e
            assign fb = cfg[IDX_EFSEG][4];
         end else begin : g_f
            assign fb = 1'b1;
         end
      end
      shadow_attr_page u_page (
         .en_i      (en),
         .rd_gate_i (rg),
         .wr_gate_i (wg),
         .fb_any_i  (fb),
         .rd_o      (pg_rd[g]),
         .wr_o      (pg_wr[g])
      );
   end

   // ---------------- regions below 16 MB ----------------
   logic   hi_hit   [NHI];
   route_e hi_route [NHI];

   for (genvar k = 0; k < NHI; k++) begin : g_hi
      shadow_attr_hiregion #(
         .TAG   (TOP_SEG_TAG - 8'(k)),
         .SPLIT (k != 0)
      ) u_hi (
         .seg_i   (seg),
         .half_i  (addr_i[15]),
         .ctl_i   (cfg[k]),
         .hit_o   (hi_hit[k]),
         .route_o (hi_route[k])
      );
   end

   route_e hi_sel;
   logic   hi_any;

   always_comb begin
      hi_sel = ROUTE_NONE;
      hi_any = 1'b0;
      for (int k = 0; k < NHI; k++) begin
         if (hi_hit[k]) begin
            hi_any = 1'b1;
            hi_sel = hi_route[k];
         end
      end
      if (!above_16m_zero) begin
         hi_any = 1'b0;
      end
   end

   // ---------------- final priority ----------------
   route_e route;

   always_comb begin
      if (ems_hit_i) begin
         route = ROUTE_INT;
      end else if (win_hit) begin
         if (win_idx < 5'(SHADOW_OFFSET)) begin
            route = ROUTE_EXT;
         end else begin
            route = wr_i ? pg_wr[sh_off[3:0]] : pg_rd[sh_off[3:0]];
         end
      end else if (hi_any) begin
         route = hi_sel;
      end else begin
         route = ROUTE_NONE;
      end
   end

   assign route_o = route;

endmodule

// File: rtl/shadow_attr_chk.sv
module shadow_attr_chk #(
   parameter int unsigned ADDR_W = 24
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cfg_we_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              wr_i,
   input logic              ems_hit_i,
   input logic [1:0]        route_o
);

   logic in_video, in_f, in_hi, in_none;

   assign in_video = (addr_i >= ADDR_W'(32'h0A0000)) && (addr_i < ADDR_W'(32'h0C0000));
   assign in_f     = (addr_i >= ADDR_W'(32'h0F0000)) && (addr_i < ADDR_W'(32'h100000));
   assign in_hi    = (addr_i >= ADDR_W'(32'hF80000)) && (addr_i < ADDR_W'(32'hFF0000));
   assign in_none  = !in_hi && !((addr_i >= ADDR_W'(32'h0A0000)) && (addr_i < ADDR_W'(32'h100000)));

   AST_EMS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ems_hit_i |-> (route_o == 2'b00)); // R10

   AST_VIDEO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ems_hit_i && in_video) |-> (route_o == 2'b01)); // R2

   AST_FSEG_NEVER_PLAIN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ems_hit_i && in_f) |-> (route_o == 2'b00 || route_o == 2'b10)); // R6

   AST_HIGH_INT_OR_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ems_hit_i && in_hi) |-> (route_o == 2'b00 || route_o == 2'b10)); // R9

   AST_UNDECODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ems_hit_i && in_none) |-> (route_o == 2'b11)); // R11

   AST_ROUTE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(cfg_we_i) && $stable(addr_i) && $stable(wr_i) && $stable(ems_hit_i))
         |-> $stable(route_o)); // R12

endmodule

bind shadow_attr_dec shadow_attr_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .cfg_we_i  (cfg_we_i),
   .addr_i    (addr_i),
   .wr_i      (wr_i),
   .ems_hit_i (ems_hit_i),
   .route_o   (route_o)
);

// File: tb/tb_shadow_attr_dec.sv
module tb_shadow_attr_dec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [7:0]  cfg_data = '0;
   logic [23:0] addr = '0;
   logic        wr = 1'b0;
   logic        ems = 1'b0;
   logic [1:0]  route;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] sh [16];

   always #5 clk = ~clk;

   shadow_attr_dec dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .cfg_we_i   (cfg_we),
      .cfg_idx_i  (cfg_idx),
      .cfg_data_i (cfg_data),
      .addr_i     (addr),
      .wr_i       (wr),
      .ems_hit_i  (ems),
      .route_o    (route)
   );

   // expected route from the requirements: 0 int, 1 ext, 2 any, 3 none
   function automatic logic [1:0] model(input logic [23:0] a, input logic w, input logic e);
      logic en, gate, any, sel;
      int r;
      if (e) return 2'd0;
      if (a >= 24'h0A0000 && a < 24'h100000) begin
         if (a < 24'h0C0000) return 2'd1;
         if (a < 24'h0E0000) begin
            en   = sh[13][(a - 24'h0C0000) / 24'h8000];
            gate = w ? sh[2][3] : sh[2][2];
            any  = (a < 24'h0D0000) ? sh[7][6] : sh[7][7];
         end else begin
            en   = (a < 24'h0F0000) ? sh[12][4] : sh[12][5];
            gate = w ? sh[2][1] : sh[2][0];
            any  = (a < 24'h0F0000) ? sh[12][4] : 1'b1;
         end
         if (en && gate) return 2'd0;
         return any ? 2'd2 : 2'd1;
      end
      if (a >= 24'hF80000 && a < 24'hFF0000) begin
         if (a[23:16] == 8'hFE) sel = sh[0][6];
         else begin
            r   = 32'hFE - int'(a[23:16]);
            sel = a[15] ? sh[r][7] : sh[r][6];
         end
         return sel ? 2'd2 : 2'd0;
      end
      return 2'd3;
   endfunction

   task automatic put_cfg(input int idx, input logic [7:0] val);
      cfg_idx  = 4'(idx);
      cfg_data = val;
      cfg_we   = 1'b1;
      @(negedge clk);
      cfg_we   = 1'b0;
      sh[idx]  = val;
   endtask

   task automatic probe(input logic [23:0] a, input logic w, input logic e, input string tag);
      logic [1:0] exp;
      addr = a; wr = w; ems = e;
      #2;
      exp = model(a, w, e);
      checks++;
      if (route !== exp) begin
         fails++;
         $display("FAIL %s addr=%h wr=%0d ems=%0d actual=%0d expected=%0d",
                  tag, a, w, e, route, exp);
      end
      @(negedge clk);
   endtask

   function automatic logic [23:0] pick_addr();
      case ($urandom % 4)
         0:       return 24'h0A0000 + 24'($urandom % 32'h60000);
         1:       return 24'hF80000 + 24'($urandom % 32'h70000);
         2:       return 24'($urandom);
         default: return 24'($urandom % 32'h0A0000);
      endcase
   endfunction

   initial begin
      #(2_000_000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) sh[i] = 8'h00;
      sh[0] = 8'h02;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset defaults
      probe(24'h0C4000, 0, 0, "R1 C seg read");
      probe(24'h0D8000, 1, 0, "R1 D seg write");
      probe(24'h0E4000, 0, 0, "R1 E seg read");
      probe(24'h0F0000, 0, 0, "R1 F seg read");
      probe(24'hFE0000, 0, 0, "R1 top region");
      probe(24'hF88000, 1, 0, "R1 split region");

      // R2 display pages never shadowed
      put_cfg(2, 8'hFF); put_cfg(13, 8'hFF); put_cfg(12, 8'hFF); put_cfg(7, 8'hFF);
      probe(24'h0A0000, 0, 0, "R2 video read");
      probe(24'h0BFFFF, 1, 0, "R2 video write");

      // R3 per-32KB enables with both gates; R12 writes take effect next edge
      put_cfg(2, 8'h0C); put_cfg(13, 8'h02); put_cfg(7, 8'h00);
      probe(24'h0C8000, 0, 0, "R3 enabled block read");
      probe(24'h0CC000, 1, 0, "R3 enabled block write");
      probe(24'h0C0000, 0, 0, "R3 disabled block");
      probe(24'h0D8000, 1, 0, "R12 neighbour block unchanged");

      // R7 independent directions
      put_cfg(2, 8'h04);
      probe(24'h0C8000, 0, 0, "R7 read-only gate read");
      probe(24'h0C8000, 1, 0, "R7 read-only gate write");
      put_cfg(2, 8'h08);
      probe(24'h0C8000, 0, 0, "R7 write-only gate read");
      probe(24'h0C8000, 1, 0, "R7 write-only gate write");

      // R4 fallback selects
      put_cfg(13, 8'h00); put_cfg(7, 8'h40);
      probe(24'h0C0000, 0, 0, "R4 C fallback any");
      probe(24'h0D0000, 0, 0, "R4 D fallback ext");
      put_cfg(7, 8'h80);
      probe(24'h0C0000, 1, 0, "R4 C fallback ext");
      probe(24'h0D4000, 1, 0, "R4 D fallback any");

      // R5 E/F enables
      put_cfg(2, 8'h03); put_cfg(12, 8'h20);
      probe(24'h0F0000, 0, 0, "R5 F enabled");
      probe(24'h0E0000, 0, 0, "R5 E disabled");
      put_cfg(12, 8'h10);
      probe(24'h0E0000, 1, 0, "R5 E enabled");
      probe(24'h0FC000, 1, 0, "R5 F disabled");

      // R6 E/F fallbacks
      put_cfg(2, 8'h00);
      probe(24'h0E8000, 0, 0, "R6 E fallback any");
      put_cfg(12, 8'h00);
      probe(24'h0E8000, 0, 0, "R6 E fallback ext");
      probe(24'h0FC000, 1, 0, "R6 F fallback any");

      // R8 top 64KB region
      put_cfg(0, 8'h40);
      probe(24'hFE0000, 0, 0, "R8 top region any");
      probe(24'hFEFFFF, 1, 0, "R8 top region end");

      // R9 split regions
      put_cfg(3, 8'h80);
      probe(24'hFB8000, 0, 0, "R9 upper half any");
      probe(24'hFB0000, 0, 0, "R9 lower half int");
      put_cfg(6, 8'h40);
      probe(24'hF80000, 1, 0, "R9 lowest region lower");
      probe(24'hF88000, 1, 0, "R9 lowest region upper");

      // R10 expanded-memory override
      probe(24'h0F0000, 0, 1, "R10 override F seg");
      probe(24'hFB8000, 1, 1, "R10 override high");
      probe(24'h100000, 0, 1, "R10 override undecoded");

      // R11 outside windows
      probe(24'h100000, 0, 0, "R11 above 1M");
      probe(24'h09FFFF, 0, 0, "R11 below window");
      probe(24'hFF0000, 0, 0, "R11 top 64K");
      probe(24'hF7FFFF, 1, 0, "R11 below high band");

      // random mix, all requirements R1..R12 via model
      for (int it = 0; it < 600; it++) begin
         if ((it % 6) == 0) begin
            int idxs [10] = '{0, 1, 2, 3, 4, 5, 6, 7, 12, 13};
            put_cfg(idxs[$urandom % 10], 8'($urandom));
         end
         probe(pick_addr(), 1'($urandom), (($urandom % 8) == 0), "R12 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule